// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block sits beside a small direct-mapped cache directory of one core that runs hardware transactions. It tracks, per line, whether the running transaction has speculatively read or speculatively written the line. Remote bus writes and upgrades are snooped at line granularity. If one of them lands on a line the transaction has read, the conflict is reported in the same cycle. The block then drops every marked line and sends a one-cycle rollback pulse to the core.

Transactional stores never reach the bus while the transaction runs. Their addresses are held in a small write buffer. On commit that buffer is drained to the bus in arrival order, one entry per granted cycle, and then all marks are cleared at once. A request that would evict a marked line is stalled rather than served. A write buffer that fills up makes the block hold the bus until the transaction has committed. Only addresses, marks, the write buffer and control are modelled; data and the coherence protocol are not.

Top module: `txn_conflict_tracker`

## Requirements
- R1: A transactional load accepted while a transaction is active sets the read mark of its line. Lines are indexed by address bits [7:4], with the tag taken from bits [31:8].
- R2: A transactional store accepted while a transaction is active sets the write mark of its line and appends its full address to the write buffer.
- R3: `conflict` is high in the same cycle as a valid snoop when all of the following hold: a transaction is active, and the snooped line address (request address bits [31:4]) has a matching tag on a valid line whose read mark is set. A tag mismatch gives no conflict, and so does a snoop outside a transaction.
- R4: A snoop to a line that carries only a write mark raises no conflict.
- R5: During commit, `bus_wr_valid` presents the oldest buffered address. One entry is removed per cycle in which `bus_grant` is high, in store order. Without a grant the presented address is unchanged.
- R6: `commit_done` is high in the first commit cycle in which the buffer is empty. The next cycle the block is idle with all marks cleared, so a request that replaces a formerly marked line is no longer stalled.
- R7: A conflict or a `tx_abort` during a transaction does the following at the next edge: it invalidates every marked line, leaves unmarked lines valid, and empties the write buffer. `rollback` is high for exactly the one following cycle.
- R8: A request whose index maps to a valid marked line with a different tag is stalled (`req_stall` high) and leaves the directory unchanged.
- R9: A transactional store is stalled while the write buffer is full. `bus_hold` rises the cycle after the buffer is full during a transaction and stays high until commit finishes.
- R10: After reset the block is idle, every line is invalid, and `conflict`, `rollback`, `commit_done`, `bus_hold` and `bus_wr_valid` are low.
- R11: All requests are stalled during commit. `tx_begin` starts a transaction only from idle, and `tx_commit` outside a transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | Request is a store |
| req_tx | input | 1 | Request belongs to the transaction |
| req_addr | input | 32 | Request byte address |
| req_hit | output | 1 | Request line is valid with matching tag |
| req_stall | output | 1 | Request not accepted this cycle |
| snoop_valid | input | 1 | Remote write or upgrade seen on the bus |
| snoop_line | input | 28 | Snooped line address |
| conflict | output | 1 | Snoop hit a read-marked line |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the transaction |
| tx_abort | input | 1 | Abort the transaction |
| tx_active | output | 1 | A transaction is running |
| rollback | output | 1 | One-cycle pulse telling the core to roll back |
| commit_done | output | 1 | Commit finished this cycle |
| bus_hold | output | 1 | Request to keep ownership of the bus |
| bus_grant | input | 1 | Bus accepts the presented buffered store |
| bus_wr_valid | output | 1 | A buffered store is presented to the bus |
| bus_wr_addr | output | 32 | Address of the presented buffered store |

## Verification
On every cycle the assertions check the following. Each conflict is followed by a single rollback pulse. The write buffer is never pushed when full or popped when empty. No marks survive an abort or a commit, no allocation replaces a marked line, and the bus hold never outlives the transaction. Other properties depend on the addresses involved, and only the bench scenarios show them: which lines keep their marks, and that write-only lines and tag mismatches stay silent. The same holds for drain order under withheld grants, unmarked lines surviving an invalidation, and the stall and hold timing around a full buffer.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_COMMIT = 2'd2
  } tx_state_e;

  // next position in a ring of the given depth
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos + 1 == depth) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/tct_directory.sv
module tct_directory #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             alloc_en,
  input  logic             set_rd,
  input  logic             set_wr,
  input  logic             kill,
  input  logic             flash,
  output logic             req_hit,
  output logic             req_marked,
  output logic             snp_rd_hit,
  output logic             any_mark
);
  logic [LINES-1:0] valid_vec, rd_vec, wr_vec;
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             v_q, r_q, w_q;
    logic [TAG_W-1:0] t_q;
    logic             here, same;
    assign here = alloc_en && (req_idx == IDX_W'(i));
    assign same = v_q && (t_q == req_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        w_q <= 1'b0;
        t_q <= '0;
      end else if (kill) begin
        if (r_q || w_q) v_q <= 1'b0;
        r_q <= 1'b0;
        w_q <= 1'b0;
      end else begin
        if (flash) begin
          r_q <= 1'b0;
          w_q <= 1'b0;
        end
        if (here) begin
          if (same) begin
            r_q <= r_q | set_rd;
            w_q <= w_q | set_wr;
          end else begin
            v_q <= 1'b1;
            t_q <= req_tag;
            r_q <= set_rd;
            w_q <= set_wr;
          end
        end
      end
    end

    assign valid_vec[i] = v_q;
    assign rd_vec[i]    = r_q;
    assign wr_vec[i]    = w_q;
    assign tag_arr[i]   = t_q;
  end

  assign req_hit    = valid_vec[req_idx] && (tag_arr[req_idx] == req_tag);
  assign req_marked = valid_vec[req_idx] && (rd_vec[req_idx] || wr_vec[req_idx]);
  assign snp_rd_hit = valid_vec[snp_idx] && rd_vec[snp_idx] && (tag_arr[snp_idx] == snp_tag);
  assign any_mark   = |(rd_vec | wr_vec);

  assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !any_mark);
  assert_flash_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flash |=> !any_mark);
  assert_no_marked_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !(req_marked && !req_hit));
endmodule

// File: rtl/tct_write_buffer.sv
module tct_write_buffer import tct_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic              clear,
  output logic [ADDR_W-1:0] head_addr,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return PTR_W'(ring_next(int'(p), DEPTH));
  endfunction

  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));
  assign head_addr = slot_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (clear) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) begin
        slot_q[wr_ptr_q] <= push_addr;
        wr_ptr_q <= adv(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= adv(rd_ptr_q);
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tct_control.sv
module tct_control import tct_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_begin,
  input  logic      tx_commit,
  input  logic      tx_abort,
  input  logic      conflict,
  input  logic      wb_empty,
  input  logic      wb_full,
  output tx_state_e state,
  output logic      active,
  output logic      committing,
  output logic      kill,
  output logic      commit_done,
  output logic      rollback,
  output logic      bus_hold
);
  tx_state_e state_q, state_d;
  logic      rollback_q, hold_q;

  assign state       = state_q;
  assign active      = (state_q == ST_ACTIVE);
  assign committing  = (state_q == ST_COMMIT);
  assign kill        = active && (conflict || tx_abort);
  assign commit_done = committing && wb_empty;
  assign rollback    = rollback_q;
  assign bus_hold    = hold_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (tx_begin) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (kill)           state_d = ST_IDLE;
        else if (tx_commit) state_d = ST_COMMIT;
      end
      ST_COMMIT: if (wb_empty) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rollback_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      rollback_q <= kill;
      if (kill || commit_done)   hold_q <= 1'b0;
      else if (active && wb_full) hold_q <= 1'b1;
    end
  end

  assert_conflict_rollback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> rollback);
  assert_rollback_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> !rollback);
  assert_hold_in_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> (state_q != ST_IDLE));
  assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (state_q == ST_IDLE));
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker import tct_pkg::*; #(
  parameter int LINES      = 16,
  parameter int WB_DEPTH   = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic                               req_tx,
  input  logic [ADDR_W-1:0]                  req_addr,
  output logic                               req_hit,
  output logic                               req_stall,
  input  logic                               snoop_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snoop_line,
  output logic                               conflict,
  input  logic                               tx_begin,
  input  logic                               tx_commit,
  input  logic                               tx_abort,
  output logic                               tx_active,
  output logic                               rollback,
  output logic                               commit_done,
  output logic                               bus_hold,
  input  logic                               bus_grant,
  output logic                               bus_wr_valid,
  output logic [ADDR_W-1:0]                  bus_wr_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] line_index(input logic [LINE_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] line_tag(input logic [LINE_W-1:0] l);
    return l[LINE_W-1 -: TAG_W];
  endfunction

  tx_state_e state;
  logic active, committing, kill;
  logic wb_empty, wb_full, wb_push, wb_pop;
  logic dir_hit, dir_marked, snp_rd_hit, any_mark;
  logic tx_load, tx_store, evict_block, accept;

  assign tx_load     = req_valid && !req_write && req_tx && active;
  assign tx_store    = req_valid &&  req_write && req_tx && active;
  assign evict_block = req_valid && dir_marked && !dir_hit;
  assign req_stall   = req_valid && (committing || evict_block || kill || (tx_store && wb_full));
  assign accept      = req_valid && !req_stall;
  assign wb_push     = accept && tx_store;
  assign wb_pop      = committing && bus_grant && !wb_empty;
  assign conflict    = snoop_valid && active && snp_rd_hit;

  assign req_hit      = dir_hit;
  assign tx_active    = active;
  assign bus_wr_valid = committing && !wb_empty;

  tct_directory #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_idx    (addr_index(req_addr)),
    .req_tag    (addr_tag(req_addr)),
    .snp_idx    (line_index(snoop_line)),
    .snp_tag    (line_tag(snoop_line)),
    .alloc_en   (accept),
    .set_rd     (accept && tx_load),
    .set_wr     (accept && tx_store),
    .kill       (kill),
    .flash      (commit_done),
    .req_hit    (dir_hit),
    .req_marked (dir_marked),
    .snp_rd_hit (snp_rd_hit),
    .any_mark   (any_mark)
  );

  tct_write_buffer #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wb_push),
    .push_addr (req_addr),
    .pop       (wb_pop),
    .clear     (kill),
    .head_addr (bus_wr_addr),
    .empty     (wb_empty),
    .full      (wb_full)
  );

  tct_control u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .tx_commit   (tx_commit),
    .tx_abort    (tx_abort),
    .conflict    (conflict),
    .wb_empty    (wb_empty),
    .wb_full     (wb_full),
    .state       (state),
    .active      (active),
    .committing  (committing),
    .kill        (kill),
    .commit_done (commit_done),
    .rollback    (rollback),
    .bus_hold    (bus_hold)
  );

  assert_idle_no_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !any_mark);
endmodule

// File: tb/tb_txn_conflict_tracker.sv
module tb_txn_conflict_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_tx;
  logic [31:0] req_addr;
  logic        req_hit, req_stall;
  logic        snoop_valid;
  logic [27:0] snoop_line;
  logic        conflict, tx_begin, tx_commit, tx_abort, tx_active;
  logic        rollback, commit_done, bus_hold, bus_grant, bus_wr_valid;
  logic [31:0] bus_wr_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_conflict_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_tx(req_tx), .req_addr(req_addr),
    .req_hit(req_hit), .req_stall(req_stall),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line), .conflict(conflict),
    .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort), .tx_active(tx_active),
    .rollback(rollback), .commit_done(commit_done), .bus_hold(bus_hold),
    .bus_grant(bus_grant), .bus_wr_valid(bus_wr_valid), .bus_wr_addr(bus_wr_addr)
  );

  typedef struct packed {
    logic        wr;
    logic        tx;
    logic [31:0] addr;
    logic        hit;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 32'h0000_1010, 1'b0, 1'b0},  // R1 tx load miss
    '{1'b0, 1'b1, 32'h0000_1014, 1'b1, 1'b0},  // R1 same line hits
    '{1'b1, 1'b1, 32'h0000_2020, 1'b0, 1'b0},  // R2 tx store
    '{1'b0, 1'b0, 32'h0000_3010, 1'b0, 1'b1},  // R8 evicts read-marked line
    '{1'b0, 1'b0, 32'h0000_3030, 1'b0, 1'b0},  // plain fill
    '{1'b0, 1'b0, 32'h0000_4030, 1'b0, 1'b0},  // unmarked eviction allowed
    '{1'b1, 1'b1, 32'h0000_5020, 1'b0, 1'b1},  // R8 evicts write-marked line
    '{1'b1, 1'b1, 32'h0000_2024, 1'b1, 1'b0},  // R2 second store
    '{1'b0, 1'b1, 32'h0000_1018, 1'b1, 1'b0}   // R8 line kept after stall
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input logic v, input logic w, input logic t, input logic [31:0] a);
    req_valid = v; req_write = w; req_tx = t; req_addr = a;
  endtask

  task automatic probe(input logic [31:0] a);
    set_req(1'b1, 1'b0, 1'b0, a);
  endtask

  task automatic cmd_begin();
    tx_begin = 1'b1; step(); tx_begin = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    snoop_valid = 1'b0; snoop_line = '0;
    tx_begin = 1'b0; tx_commit = 1'b0; tx_abort = 1'b0; bus_grant = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    probe(32'h0000_F0F0);
    #1;
    check("R10 hit", req_hit, 0);
    check("R10 active", tx_active, 0);
    check("R10 outputs", {conflict, rollback, commit_done, bus_hold, bus_wr_valid}, 0);
    step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);

    cmd_begin();
    #1 check("R11 begin", tx_active, 1);

    // vector table inside one transaction
    for (int i = 0; i < NV; i++) begin
      set_req(1'b1, VECS[i].wr, VECS[i].tx, VECS[i].addr);
      #1;
      check($sformatf("vec%0d hit", i), req_hit, VECS[i].hit);
      check($sformatf("vec%0d stall", i), req_stall, VECS[i].stall);
      step();
    end
    set_req(1'b0, 1'b0, 1'b0, 32'h0);

    // R4 write-only line, R3 tag mismatch
    snoop_valid = 1'b1; snoop_line = 28'h000_0202;
    #1 check("R4 write-only snoop", conflict, 0);
    snoop_line = 28'h000_0901;
    #1 check("R3 tag mismatch", conflict, 0);
    step();
    snoop_valid = 1'b0;

    // commit drain, R5
    tx_commit = 1'b1; step(); tx_commit = 1'b0;
    probe(32'h0000_0000);
    #1;
    check("R11 stall in commit", req_stall, 1);
    check("R5 valid", bus_wr_valid, 1);
    check("R5 first addr", bus_wr_addr, 32'h0000_2020);
    check("R6 not done", commit_done, 0);
    step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    #1 check("R5 held without grant", bus_wr_addr, 32'h0000_2020);
    bus_grant = 1'b1;
    step();
    #1 check("R5 second addr", bus_wr_addr, 32'h0000_2024);
    step();
    #1;
    check("R6 done", commit_done, 1);
    check("R5 drained", bus_wr_valid, 0);
    step();
    bus_grant = 1'b0;
    #1 check("R6 idle", tx_active, 0);
    probe(32'h0000_3010);
    #1 check("R6 marks cleared", req_stall, 0);
    snoop_valid = 1'b1; snoop_line = 28'h000_0202;
    #1 check("R3 no conflict idle", conflict, 0);
    step();
    snoop_valid = 1'b0;
    set_req(1'b0, 1'b0, 1'b0, 32'h0);

    // R11 commit outside transaction
    tx_commit = 1'b1; step(); tx_commit = 1'b0;
    #1 check("R11 idle commit", {commit_done, bus_wr_valid, tx_active}, 0);

    // conflict transaction
    cmd_begin();
    set_req(1'b1, 1'b0, 1'b1, 32'h0000_6050); step();
    set_req(1'b1, 1'b0, 1'b0, 32'h0000_7060); step();
    set_req(1'b1, 1'b1, 1'b1, 32'h0000_8070); step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    snoop_valid = 1'b1; snoop_line = 28'h000_0605;
    #1 check("R1 R3 conflict", conflict, 1);
    step();
    snoop_valid = 1'b0;
    #1 check("R7 rollback", rollback, 1);
    step();
    #1 check("R7 pulse ends", {rollback, tx_active}, 0);
    probe(32'h0000_6050);
    #1 check("R7 read line dropped", req_hit, 0);
    step();
    probe(32'h0000_8070);
    #1 check("R7 written line dropped", req_hit, 0);
    step();
    probe(32'h0000_7060);
    #1 check("R7 unmarked kept", req_hit, 1);
    step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    cmd_begin();
    tx_commit = 1'b1; step(); tx_commit = 1'b0;
    #1 check("R7 buffer emptied", {commit_done, bus_wr_valid}, 2'b10);
    step();

    // abort
    cmd_begin();
    set_req(1'b1, 1'b0, 1'b1, 32'h0000_A0A0); step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    tx_abort = 1'b1; step(); tx_abort = 1'b0;
    #1 check("R7 abort rollback", rollback, 1);
    step();
    probe(32'h0000_A0A0);
    #1 check("R7 abort dropped", req_hit, 0);
    step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);

    // full buffer, R9
    cmd_begin();
    for (int k = 0; k < 4; k++) begin
      set_req(1'b1, 1'b1, 1'b1, 32'h0000_0100 + 32'(k) * 32'h10);
      step();
    end
    #1 check("R9 hold not yet", bus_hold, 0);
    set_req(1'b1, 1'b1, 1'b1, 32'h0000_0140);
    #1 check("R9 store stalled full", req_stall, 1);
    step();
    set_req(1'b0, 1'b0, 1'b0, 32'h0);
    #1 check("R9 hold raised", bus_hold, 1);
    tx_commit = 1'b1; step(); tx_commit = 1'b0;
    bus_grant = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R5 R9 drain order", bus_wr_addr, 32'h0000_0100 + 32'(k) * 32'h10);
      check("R9 hold in commit", bus_hold, 1);
      step();
    end
    #1 check("R6 done after full", commit_done, 1);
    step();
    bus_grant = 1'b0;
    #1 check("R9 hold released", {bus_hold, tx_active}, 0);

    finish_run();
  end
endmodule